// File: doc/BRIEF.md
# Serial Subcarrier-Lock Frame Receiver

This block takes a one-bit serial timing stream, clocked by the pixel clock, that an upstream video decoder uses to pass on its colour-subcarrier phase increment. While idle, the receiver watches the line for a high-to-low transition. That transition marks slot 0 of a frame. From there the receiver counts a fixed window of 128 slots, one slot per clock. In the slots it knows, it picks out a 22-bit phase increment, a line-sequence flag and a synthesizer-reset flag. It ignores every other slot.

When the window closes, the receiver hands all three items to a downstream direct digital synthesizer at the same moment, together with a one-cycle load strobe. The word it presents is 32 bits wide. The received increment sits in the upper 22 bits. The lower 10 bits come from a locally held low-frequency field, a parameter whose value should stay zero. For PAL the sequence flag selects a normal line (0) or an inverted line (1). For NTSC it is kept at 0, which means no change.

Top module: `slk_frame_rx`

## Requirements
- R1: After reset, `phase_word` is 0 and `phase_load`, `line_seq` and `dds_clear` are all 0.
- R2: A frame starts only on a registered high-to-low transition of `ser_in` while the receiver is idle. A line that is low from reset onward, with no preceding high, never starts a frame.
- R3: Slots 19 to 40 carry the increment with its most significant bit first: slot 19 becomes increment bit 21 and slot 40 becomes bit 0. The increment appears on `phase_word[31:10]`, and `phase_word[9:0]` always holds the low-frequency fill (default 0).
- R4: The level in slot 67 is presented on `line_seq`.
- R5: The level in slot 68 is the synthesizer-reset flag. `dds_clear` pulses high for exactly one cycle, in the same cycle as `phase_load`, only when that flag is 1.
- R6: `phase_load` is high for exactly one cycle per frame. The new `phase_word` and `line_seq` values are visible in that same cycle, on the 128th rising edge after the edge that first registered slot 0.
- R7: Slots other than 19 to 40, 67 and 68 have no effect on any output.
- R8: Falling transitions inside the 128-slot window do not restart the count. After the window, the receiver re-arms: a high in slot 127 followed at once by a low starts the next frame with no idle gap.
- R9: Between loads, `phase_word` and `line_seq` hold their values, and `dds_clear` stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock; also the slot clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ser_in | input | 1 | Serial timing stream |
| phase_word | output | 32 | Increment in bits 31:10, low-frequency fill in bits 9:0 |
| phase_load | output | 1 | One-cycle strobe marking a new word |
| line_seq | output | 1 | Line-sequence flag from the latest frame |
| dds_clear | output | 1 | One-cycle synthesizer reset request |

## Verification
Some rules hold on every cycle, and the assertions watch them:
- the load strobe lasts one cycle, and it follows the end of every window;
- the reset pulse never appears without the load strobe;
- the outputs hold steady between loads;
- once a frame is running, the slot count keeps advancing whatever the line does.

Other behaviour shows up only in the bench's scenarios: the exact slot-to-bit mapping, the indifference to reserved slots, the 128-edge latency, refusal to start from a line held low, and back-to-back frames. The bench checks these against frames it builds itself, using both directed and random increments and reserved-slot fills.

// File: rtl/slk_pkg.sv
package slk_pkg;

    typedef enum logic {
        SLK_IDLE = 1'b0,
        SLK_RUN  = 1'b1
    } slk_state_e;

    localparam int SLK_WIN_DEF       = 128;
    localparam int SLK_INC_W_DEF     = 22;
    localparam int SLK_INC_FIRST_DEF = 19;
    localparam int SLK_SEQ_SLOT_DEF  = 67;
    localparam int SLK_CLR_SLOT_DEF  = 68;
    localparam int SLK_LOW_W_DEF     = 10;

endpackage

// File: rtl/slk_line_sense.sv
module slk_line_sense (
    input  logic clk,
    input  logic rst_n,
    input  logic ser_in,
    output logic bit_o,
    output logic fall_o
);

    typedef struct packed {
        logic cur;
        logic prev;
    } sense_t;

    sense_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        s_d.cur  = ser_in;
        s_d.prev = s_q.cur;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign bit_o  = s_q.cur;
    assign fall_o = s_q.prev & ~s_q.cur;

    // A detected fall means the line was high one cycle earlier.
    assert_fall_has_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
        fall_o |-> ($past(ser_in, 2) && !$past(ser_in, 1)));

endmodule

// File: rtl/slk_slot_ctr.sv
module slk_slot_ctr
    import slk_pkg::*;
#(
    parameter int WIN = SLK_WIN_DEF
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     fall_i,
    output logic                     slot_vld_o,
    output logic [$clog2(WIN)-1:0]   slot_o,
    output logic                     last_o
);

    localparam int          CW   = $clog2(WIN);
    localparam logic [CW-1:0] LAST = CW'(WIN - 1);

    typedef struct packed {
        slk_state_e    st;
        logic [CW-1:0] cnt;
    } ctr_t;

    ctr_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        unique case (r_q.st)
            SLK_IDLE: begin
                if (fall_i) begin
                    r_d.st  = SLK_RUN;
                    r_d.cnt = CW'(1);
                end
            end
            SLK_RUN: begin
                if (r_q.cnt == LAST) begin
                    r_d.st  = SLK_IDLE;
                    r_d.cnt = '0;
                end else begin
                    r_d.cnt = r_q.cnt + CW'(1);
                end
            end
            default: r_d = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign slot_vld_o = (r_q.st == SLK_RUN) | fall_i;
    assign slot_o     = (r_q.st == SLK_RUN) ? r_q.cnt : '0;
    assign last_o     = (r_q.st == SLK_RUN) && (r_q.cnt == LAST);

    // Running count advances by one regardless of line activity.
    assert_no_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == SLK_RUN && r_q.cnt != LAST) |=>
            (r_q.st == SLK_RUN && r_q.cnt == $past(r_q.cnt) + CW'(1)));

    // The window always closes back to idle.
    assert_rearm_R8: assert property (@(posedge clk) disable iff (!rst_n)
        last_o |=> (r_q.st == SLK_IDLE));

endmodule

// File: rtl/slk_field_grab.sv
module slk_field_grab
    import slk_pkg::*;
#(
    parameter int WIN       = SLK_WIN_DEF,
    parameter int INC_W     = SLK_INC_W_DEF,
    parameter int INC_FIRST = SLK_INC_FIRST_DEF,
    parameter int SEQ_SLOT  = SLK_SEQ_SLOT_DEF,
    parameter int CLR_SLOT  = SLK_CLR_SLOT_DEF,
    parameter bit MSB_FIRST = 1'b1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   bit_i,
    input  logic                   slot_vld_i,
    input  logic [$clog2(WIN)-1:0] slot_i,
    input  logic                   last_i,
    output logic [INC_W-1:0]       inc_o,
    output logic                   seq_o,
    output logic                   clr_o,
    output logic                   load_o
);

    localparam int INC_LAST = INC_FIRST + INC_W - 1;

    typedef struct packed {
        logic [INC_W-1:0] inc_sh;
        logic             seq_sh;
        logic             clr_sh;
        logic [INC_W-1:0] inc;
        logic             seq;
        logic             clr;
        logic             load;
    } grab_t;

    grab_t g_d, g_q;
    logic [INC_W-1:0] shifted;
    logic             in_inc, at_seq, at_clr;

    generate
        if (MSB_FIRST) begin : g_msb
            assign shifted = {g_q.inc_sh[INC_W-2:0], bit_i};
        end else begin : g_lsb
            assign shifted = {bit_i, g_q.inc_sh[INC_W-1:1]};
        end
    endgenerate

    always_comb begin
        in_inc = slot_vld_i && (int'(slot_i) >= INC_FIRST) && (int'(slot_i) <= INC_LAST);
        at_seq = slot_vld_i && (int'(slot_i) == SEQ_SLOT);
        at_clr = slot_vld_i && (int'(slot_i) == CLR_SLOT);
    end

    always_comb begin
        g_d      = g_q;
        g_d.load = 1'b0;
        g_d.clr  = 1'b0;
        if (in_inc) g_d.inc_sh = shifted;
        if (at_seq) g_d.seq_sh = bit_i;
        if (at_clr) g_d.clr_sh = bit_i;
        if (last_i) begin
            g_d.inc  = g_q.inc_sh;
            g_d.seq  = g_q.seq_sh;
            g_d.clr  = g_q.clr_sh;
            g_d.load = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            g_q <= '0;
        end else begin
            g_q <= g_d;
        end
    end

    assign inc_o  = g_q.inc;
    assign seq_o  = g_q.seq;
    assign clr_o  = g_q.clr;
    assign load_o = g_q.load;

    // Capture slots never overlap the end of the window.
    assert_capture_before_end_R3: assert property (@(posedge clk) disable iff (!rst_n)
        last_i |-> !(in_inc || at_seq || at_clr));

endmodule

// File: rtl/slk_frame_rx.sv
module slk_frame_rx
    import slk_pkg::*;
#(
    parameter int             WIN       = SLK_WIN_DEF,
    parameter int             INC_W     = SLK_INC_W_DEF,
    parameter int             INC_FIRST = SLK_INC_FIRST_DEF,
    parameter int             SEQ_SLOT  = SLK_SEQ_SLOT_DEF,
    parameter int             CLR_SLOT  = SLK_CLR_SLOT_DEF,
    parameter int             LOW_W     = SLK_LOW_W_DEF,
    parameter logic [LOW_W-1:0] LOW_FILL = '0
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     ser_in,
    output logic [INC_W+LOW_W-1:0]   phase_word,
    output logic                     phase_load,
    output logic                     line_seq,
    output logic                     dds_clear
);

    localparam int CW = $clog2(WIN);

    logic          bit_w, fall_w, slot_vld_w, last_w;
    logic [CW-1:0] slot_w;
    logic [INC_W-1:0] inc_w;

    slk_line_sense u_sense (
        .clk    (clk),
        .rst_n  (rst_n),
        .ser_in (ser_in),
        .bit_o  (bit_w),
        .fall_o (fall_w)
    );

    slk_slot_ctr #(.WIN(WIN)) u_ctr (
        .clk        (clk),
        .rst_n      (rst_n),
        .fall_i     (fall_w),
        .slot_vld_o (slot_vld_w),
        .slot_o     (slot_w),
        .last_o     (last_w)
    );

    slk_field_grab #(
        .WIN       (WIN),
        .INC_W     (INC_W),
        .INC_FIRST (INC_FIRST),
        .SEQ_SLOT  (SEQ_SLOT),
        .CLR_SLOT  (CLR_SLOT),
        .MSB_FIRST (1'b1)
    ) u_grab (
        .clk        (clk),
        .rst_n      (rst_n),
        .bit_i      (bit_w),
        .slot_vld_i (slot_vld_w),
        .slot_i     (slot_w),
        .last_i     (last_w),
        .inc_o      (inc_w),
        .seq_o      (line_seq),
        .clr_o      (dds_clear),
        .load_o     (phase_load)
    );

    assign phase_word = {inc_w, LOW_FILL};

    assert_load_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        phase_load |=> !phase_load);

    assert_load_after_window_R6: assert property (@(posedge clk) disable iff (!rst_n)
        last_w |=> phase_load);

    assert_clear_with_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
        dds_clear |-> phase_load);

    assert_hold_between_loads_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !phase_load |-> ($stable(phase_word) && $stable(line_seq) && !dds_clear));

endmodule

// File: tb/sim_slk_frame_rx.sv
`timescale 1ns/1ps
module sim_slk_frame_rx;

    localparam int WIN = 128, INC_W = 22, INC_FIRST = 19, SEQ_SLOT = 67, CLR_SLOT = 68;

    logic clk = 1'b0, rst_n = 1'b0, ser_in = 1'b0;
    logic [31:0] phase_word;
    logic phase_load, line_seq, dds_clear;

    int total = 0, bad = 0, cyc = 0, loads = 0, clears = 0, last_t0 = 0;
    logic [31:0] mon_word [8];
    logic        mon_seq  [8];
    logic        mon_clr  [8];
    int          mon_t    [8];
    bit          finished = 1'b0;

    slk_frame_rx u0 (
        .clk(clk), .rst_n(rst_n), .ser_in(ser_in),
        .phase_word(phase_word), .phase_load(phase_load),
        .line_seq(line_seq), .dds_clear(dds_clear)
    );

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    always @(posedge clk) begin
        #1;
        if (rst_n && phase_load) begin
            mon_word[loads % 8] = phase_word;
            mon_seq[loads % 8]  = line_seq;
            mon_clr[loads % 8]  = dds_clear;
            mon_t[loads % 8]    = cyc;
            loads = loads + 1;
        end
        if (rst_n && dds_clear) clears = clears + 1;
    end

    task automatic chk(string req, bit ok, logic [31:0] act, logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [WIN-1:0] mk_frame(logic [21:0] inc, logic seq, logic clr,
                                                logic [WIN-1:0] fill);
        logic [WIN-1:0] f = fill;
        f[0] = 1'b0;
        for (int i = 0; i < INC_W; i++) f[INC_FIRST + i] = inc[INC_W - 1 - i];
        f[SEQ_SLOT] = seq;
        f[CLR_SLOT] = clr;
        return f;
    endfunction

    task automatic send(logic [WIN-1:0] f);
        for (int k = 0; k < WIN; k++) begin
            @(negedge clk);
            ser_in = f[k];
            if (k == 0) last_t0 = cyc + 1;
        end
    endtask

    task automatic idle(int n, logic lvl);
        repeat (n) begin
            @(negedge clk);
            ser_in = lvl;
        end
    endtask

    task automatic frame_check(logic [21:0] inc, logic seq, logic clr, logic [WIN-1:0] fill);
        int l0 = loads, c0 = clears, idx;
        idle(2, 1'b1);
        send(mk_frame(inc, seq, clr, fill));
        idle(3, 1'b1);
        idx = l0 % 8;
        chk("R6 one load per frame", loads == l0 + 1, loads, l0 + 1);
        chk("R3 increment word", mon_word[idx] == {inc, 10'b0}, mon_word[idx], {inc, 10'b0});
        chk("R4 sequence flag", mon_seq[idx] == seq, mon_seq[idx], seq);
        chk("R5 clear pulse", (clears - c0) == int'(clr) && mon_clr[idx] == clr, clears - c0, clr);
        chk("R6 latency", mon_t[idx] - last_t0 == 128, mon_t[idx] - last_t0, 128);
    endtask

    initial begin
        logic [WIN-1:0] fa, fb, rnd_fill;
        logic [31:0] w_keep;
        int l0;
        void'($urandom(32'd5171));
        // R1 / R2: line low through and after reset.
        repeat (10) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset word", phase_word == 0, phase_word, 0);
        chk("R1 reset strobes", {phase_load, line_seq, dds_clear} == 3'b000,
            {phase_load, line_seq, dds_clear}, 0);
        idle(60, 1'b0);
        chk("R2 no start from held low", loads == 0, loads, 0);

        // Directed corner frames.
        frame_check(22'h3FFFFF, 1'b1, 1'b1, '0);
        frame_check(22'h000000, 1'b0, 1'b0, '1);            // R7 reserved ones ignored
        frame_check(22'h2AAAAA, 1'b1, 1'b0, '0);
        frame_check(22'h2AAAAA, 1'b1, 1'b0, '1);            // R7 same fields, other fill
        frame_check(22'h000001, 1'b0, 1'b1, {WIN{1'b1}} ^ {64{2'b10}});
        frame_check(22'h200000, 1'b1, 1'b0, {64{2'b10}});   // R8 many falls inside

        // R9: hold over a long idle.
        w_keep = phase_word; l0 = loads;
        idle(300, 1'b1);
        chk("R9 word holds", phase_word == w_keep && loads == l0, phase_word, w_keep);
        chk("R9 clear idle", dds_clear == 1'b0, dds_clear, 0);

        // R8: line left low after a frame does not retrigger.
        idle(2, 1'b1);
        fa = mk_frame(22'h155555, 1'b0, 1'b0, '0);
        l0 = loads;
        send(fa);
        idle(200, 1'b0);
        chk("R8 no retrigger on low", loads == l0 + 1, loads, l0 + 1);
        frame_check(22'h0F0F0F, 1'b1, 1'b1, '0);

        // R8: back-to-back frames with no gap.
        fa = mk_frame(22'h123456, 1'b1, 1'b0, '0);
        fa[WIN-1] = 1'b1;
        fb = mk_frame(22'h3ABCDE, 1'b0, 1'b1, '1);
        l0 = loads;
        idle(2, 1'b1);
        send(fa);
        send(fb);
        idle(3, 1'b1);
        chk("R8 back-to-back count", loads == l0 + 2, loads, l0 + 2);
        chk("R8 first of pair", mon_word[l0 % 8] == {22'h123456, 10'b0}, mon_word[l0 % 8],
            {22'h123456, 10'b0});
        chk("R8 second of pair", mon_word[(l0 + 1) % 8] == {22'h3ABCDE, 10'b0},
            mon_word[(l0 + 1) % 8], {22'h3ABCDE, 10'b0});
        chk("R6 second latency", mon_t[(l0 + 1) % 8] - last_t0 == 128,
            mon_t[(l0 + 1) % 8] - last_t0, 128);

        // Random frames: R3 R4 R5 R6 R7.
        for (int n = 0; n < 25; n++) begin
            rnd_fill = {$urandom(), $urandom(), $urandom(), $urandom()};
            frame_check(22'($urandom()), 1'($urandom()), 1'($urandom()), rnd_fill);
            idle(int'($urandom() % 5), 1'b1);
        end

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(5.0 * 150000);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule